// File: doc/BRIEF.md
# LCD Controller Register and Interrupt Unit

This block is the register file of a small LCD controller. A host reaches it over a simple word bus: one request per cycle, made of valid, write, address and write data. Read data comes back one cycle after the request. The block holds these registers:

- control
- three timing words
- a subpanel word
- a status word

Each stored field is presented on its own output pin for the rest of the controller. The pixel engine reports three events on single-cycle pulse inputs: frame done, palette loaded, and sync error. The block latches each event into a sticky status flag and merges the flags into one level-sensitive interrupt line.

The read-back values are not plain copies of what was written. The control and timing reads OR fixed constant bits into the live fields. The TFT select shows up at two bit positions in the control read. The panel width and height are written as the count minus one, and the block presents them to the controller as the full count.

Top module: `lcd_regbank`

## Requirements
- R1: After reset every stored field and status flag is zero, `irq` is low and `bus_rdata` is zero. As a result, `panel_width` and `panel_height` read 1 and a control read returns 0xfe000c34.
- R2: A write to offset 0x00 stores these fields: enable from bit 0, mono from bit 1, interrupt enables from bits 4:3, TFT select from bit 7 and palette mode from bits 21:20. It also stores the write data ANDed with 0x01cff300 as extra control bits. A read of 0x00 returns the OR of five terms: those fields at the same positions, the TFT bit again at bit 23, the extra bits, and the constant 0xfe000c34.
- R3: A write to offset 0x04 stores bits 9:0 as width minus one and bits 31:10 as auxiliary timing. `panel_width` is the 10-bit field plus one, on 11 bits. A read returns the stored word with bits 3:0 forced to 1.
- R4: Offset 0x08 is laid out the same way for height (`panel_height`, `timing1_aux`). Its read returns the stored word unchanged.
- R5: Offset 0x0c stores all 32 bits. Its read returns them with bits 31:26 forced to 1.
- R6: A read of offset 0x10 returns frame done at bit 0, sync error at bit 2 and palette done at bit 6, with zero elsewhere. Writes to 0x10 change nothing.
- R7: A write to offset 0x14 keeps only the bits under mask 0xa1ffffff. A read returns the kept value.
- R8: A status flag is set in the cycle after its pulse input is high. It stays set until a write to 0x00 with bit 0 clear. A pulse that arrives in the same cycle as that clearing write wins, so its flag is set.
- R9: `irq` is high when any of these holds: frame done with interrupt enable bit 0 set, palette done with enable bit 1 set, or sync error. `irq` follows the registered flags, so it rises one cycle after the pulse.
- R10: An offset is unmapped when it is not a multiple of four or lies above 0x14. A read of an unmapped offset returns zero, and a write to one changes no register or flag.
- R11: `bus_rdata` updates at the clock edge that accepts a read and holds its value through writes and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | Request valid this cycle |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| frame_done_pulse | input | 1 | Frame finished event |
| palette_done_pulse | input | 1 | Palette loaded event |
| sync_err_pulse | input | 1 | Sync error event |
| ctl_enable | output | 1 | Controller enable |
| ctl_mono | output | 1 | Monochrome select |
| ctl_irq_en | output | 2 | Interrupt enables (bit 0 frame, bit 1 palette) |
| ctl_tft | output | 1 | TFT panel select |
| ctl_pal_mode | output | 2 | Palette loading mode |
| ctl_extra | output | 32 | Extra control bits under 0x01cff300 |
| panel_width | output | 11 | Width in pixels (field plus one) |
| timing0_aux | output | 22 | Upper bits of timing word 0 |
| panel_height | output | 11 | Height in lines (field plus one) |
| timing1_aux | output | 22 | Upper bits of timing word 1 |
| timing2 | output | 32 | Timing word 2 as written |
| subpanel | output | 32 | Masked subpanel word |
| st_frame_done | output | 1 | Frame done flag |
| st_palette_done | output | 1 | Palette done flag |
| st_sync_error | output | 1 | Sync error flag |
| irq | output | 1 | Combined interrupt level |

## Verification
The register paths are driven with a walking one across all 32 bits and with a set of dense and alternating words. The walking one exposes a wrong mask, a missing mirror or a misplaced field one bit at a time. The dense words show the forced-one constants and the minus-one arithmetic at the 10-bit limit.

The interrupt is tried with all four enable settings against all eight combinations of the three events. This separates the gated sources from the ungated sync error. Each combination also checks the status bit positions, writes to the status word, and the clear-on-disable behaviour.

Finally, every one of the 250 unmapped offsets is written with all ones and then read back. This shows both that unmapped reads return zero and that the mapped registers are untouched.

// File: rtl/lcd_regbank_pkg.sv
package lcd_regbank_pkg;

  localparam int NFLAG     = 3;
  localparam int FLG_FRAME = 0;
  localparam int FLG_PAL   = 1;
  localparam int FLG_SYNC  = 2;

  localparam int NREG    = 6;
  localparam int RG_CTRL = 0;
  localparam int RG_TIM0 = 1;
  localparam int RG_TIM1 = 2;
  localparam int RG_TIM2 = 3;
  localparam int RG_STAT = 4;
  localparam int RG_SUBP = 5;

  localparam int DIM_W = 10;
  localparam int AUX_W = 32 - DIM_W;

  localparam logic [31:0] CTRL_KEEP_MASK = 32'h01cf_f300;
  localparam logic [31:0] CTRL_READ_ONES = 32'hfe00_0c34;
  localparam logic [31:0] TIM0_READ_ONES = 32'h0000_000f;
  localparam logic [31:0] TIM2_READ_ONES = 32'hfc00_0000;
  localparam logic [31:0] SUBP_KEEP_MASK = 32'ha1ff_ffff;

  typedef struct packed {
    logic [1:0]  pal_mode;
    logic        tft;
    logic [1:0]  irq_en;
    logic        mono;
    logic        enable;
    logic [31:0] extra;
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(logic [31:0] w);
    ctrl_t c;
    c.enable   = w[0];
    c.mono     = w[1];
    c.irq_en   = w[4:3];
    c.tft      = w[7];
    c.pal_mode = w[21:20];
    c.extra    = w & CTRL_KEEP_MASK;
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(ctrl_t c);
    logic [31:0] w;
    w = c.extra | CTRL_READ_ONES;
    w[0]     = w[0] | c.enable;
    w[1]     = w[1] | c.mono;
    w[4:3]   = w[4:3] | c.irq_en;
    w[7]     = w[7] | c.tft;
    w[21:20] = w[21:20] | c.pal_mode;
    w[23]    = w[23] | c.tft;
    return w;
  endfunction

  function automatic logic [31:0] tim_pack(logic [AUX_W-1:0] aux,
                                           logic [DIM_W-1:0] m1,
                                           logic [31:0] ones);
    return {aux, m1} | ones;
  endfunction

  function automatic logic [31:0] stat_pack(logic [NFLAG-1:0] f);
    logic [31:0] w;
    w    = '0;
    w[0] = f[FLG_FRAME];
    w[2] = f[FLG_SYNC];
    w[6] = f[FLG_PAL];
    return w;
  endfunction

  function automatic logic [DIM_W:0] span_of(logic [DIM_W-1:0] m1);
    return {1'b0, m1} + {{DIM_W{1'b0}}, 1'b1};
  endfunction

endpackage

// File: rtl/lcd_bus_decode.sv
module lcd_bus_decode #(
  parameter int ADDR_W = 8,
  parameter int NREG   = 6
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output logic [NREG-1:0]   wr_sel,
  output logic [NREG-1:0]   rd_sel,
  output logic              rd_stb,
  output logic              rd_hit
);
  localparam int IDX_W = ADDR_W - 2;

  logic aligned;
  assign aligned = (addr[1:0] == 2'b00);
  assign rd_stb  = valid & ~write;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic hit;
    assign hit       = aligned && (addr[ADDR_W-1:2] == IDX_W'(i));
    assign wr_sel[i] = valid & write & hit;
    assign rd_sel[i] = rd_stb & hit;
  end

  assign rd_hit = |rd_sel;
endmodule

// File: rtl/lcd_event_flags.sv
module lcd_event_flags #(
  parameter int NSRC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_pulse,
  input  logic            clr,
  output logic [NSRC-1:0] flags
);
  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)            flags[i] <= 1'b0;
      else if (set_pulse[i]) flags[i] <= 1'b1;
      else if (clr)          flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/lcd_irq_merge.sv
module lcd_irq_merge
  import lcd_regbank_pkg::*;
(
  input  logic [NFLAG-1:0] flags,
  input  logic [1:0]       irq_en,
  output logic             irq
);
  logic frame_req, pal_req;
  assign frame_req = flags[FLG_FRAME] & irq_en[0];
  assign pal_req   = flags[FLG_PAL]   & irq_en[1];
  assign irq       = frame_req | pal_req | flags[FLG_SYNC];
endmodule

// File: rtl/lcd_regbank.sv
module lcd_regbank
  import lcd_regbank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              frame_done_pulse,
  input  logic              palette_done_pulse,
  input  logic              sync_err_pulse,
  output logic              ctl_enable,
  output logic              ctl_mono,
  output logic [1:0]        ctl_irq_en,
  output logic              ctl_tft,
  output logic [1:0]        ctl_pal_mode,
  output logic [31:0]       ctl_extra,
  output logic [DIM_W:0]    panel_width,
  output logic [AUX_W-1:0]  timing0_aux,
  output logic [DIM_W:0]    panel_height,
  output logic [AUX_W-1:0]  timing1_aux,
  output logic [31:0]       timing2,
  output logic [31:0]       subpanel,
  output logic              st_frame_done,
  output logic              st_palette_done,
  output logic              st_sync_error,
  output logic              irq
);
  logic [NREG-1:0]  wr_sel, rd_sel;
  logic             rd_stb, rd_hit;
  logic [NFLAG-1:0] set_vec, flags;
  logic             flag_clr;

  ctrl_t            ctrl_q;
  logic [AUX_W-1:0] tim0_aux_q, tim1_aux_q;
  logic [DIM_W-1:0] w_m1_q, h_m1_q;
  logic [31:0]      tim2_q, subp_q, rdata_q, rd_word;

  lcd_bus_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) u_dec (
    .valid  (bus_valid),
    .write  (bus_write),
    .addr   (bus_addr),
    .wr_sel (wr_sel),
    .rd_sel (rd_sel),
    .rd_stb (rd_stb),
    .rd_hit (rd_hit)
  );

  assign set_vec[FLG_FRAME] = frame_done_pulse;
  assign set_vec[FLG_PAL]   = palette_done_pulse;
  assign set_vec[FLG_SYNC]  = sync_err_pulse;
  assign flag_clr = wr_sel[RG_CTRL] & ~bus_wdata[0];

  lcd_event_flags #(.NSRC(NFLAG)) u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_pulse (set_vec),
    .clr       (flag_clr),
    .flags     (flags)
  );

  lcd_irq_merge u_irq (
    .flags  (flags),
    .irq_en (ctrl_q.irq_en),
    .irq    (irq)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q     <= '0;
      tim0_aux_q <= '0;
      w_m1_q     <= '0;
      tim1_aux_q <= '0;
      h_m1_q     <= '0;
      tim2_q     <= '0;
      subp_q     <= '0;
    end else begin
      if (wr_sel[RG_CTRL]) ctrl_q <= ctrl_unpack(bus_wdata);
      if (wr_sel[RG_TIM0]) {tim0_aux_q, w_m1_q} <= bus_wdata;
      if (wr_sel[RG_TIM1]) {tim1_aux_q, h_m1_q} <= bus_wdata;
      if (wr_sel[RG_TIM2]) tim2_q <= bus_wdata;
      if (wr_sel[RG_SUBP]) subp_q <= bus_wdata & SUBP_KEEP_MASK;
    end
  end

  always_comb begin
    rd_word = '0;
    if (rd_sel[RG_CTRL]) rd_word = ctrl_pack(ctrl_q);
    if (rd_sel[RG_TIM0]) rd_word = tim_pack(tim0_aux_q, w_m1_q, TIM0_READ_ONES);
    if (rd_sel[RG_TIM1]) rd_word = tim_pack(tim1_aux_q, h_m1_q, '0);
    if (rd_sel[RG_TIM2]) rd_word = tim2_q | TIM2_READ_ONES;
    if (rd_sel[RG_STAT]) rd_word = stat_pack(flags);
    if (rd_sel[RG_SUBP]) rd_word = subp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      rdata_q <= '0;
    else if (rd_stb) rdata_q <= rd_word;
  end

  assign bus_rdata       = rdata_q;
  assign ctl_enable      = ctrl_q.enable;
  assign ctl_mono        = ctrl_q.mono;
  assign ctl_irq_en      = ctrl_q.irq_en;
  assign ctl_tft         = ctrl_q.tft;
  assign ctl_pal_mode    = ctrl_q.pal_mode;
  assign ctl_extra       = ctrl_q.extra;
  assign panel_width     = span_of(w_m1_q);
  assign timing0_aux     = tim0_aux_q;
  assign panel_height    = span_of(h_m1_q);
  assign timing1_aux     = tim1_aux_q;
  assign timing2         = tim2_q;
  assign subpanel        = subp_q;
  assign st_frame_done   = flags[FLG_FRAME];
  assign st_palette_done = flags[FLG_PAL];
  assign st_sync_error   = flags[FLG_SYNC];
endmodule

// File: rtl/lcd_regbank_chk.sv
module lcd_regbank_chk
  import lcd_regbank_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [NREG-1:0]  wr_sel,
  input logic [NREG-1:0]  rd_sel,
  input logic             rd_stb,
  input logic             rd_hit,
  input logic [31:0]      bus_rdata,
  input logic [NFLAG-1:0] flags,
  input logic [NFLAG-1:0] set_vec,
  input logic             flag_clr,
  input logic             irq
);
  AST_CTRL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel[RG_CTRL] |=> ((bus_rdata & CTRL_READ_ONES) == CTRL_READ_ONES)); // R2
  AST_TIM2_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel[RG_TIM2] |=> (bus_rdata[31:26] == 6'h3f)); // R5
  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flags & $past(set_vec)) == $past(set_vec))); // R8
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && set_vec == '0) |=> (flags == '0)); // R8
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec == '0 && !flag_clr) |=> $stable(flags)); // R8
  AST_SYNC_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    flags[FLG_SYNC] |-> irq); // R9
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags != '0)); // R9
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !rd_hit) |=> (bus_rdata == 32'h0)); // R10
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_sel, rd_sel})); // R10
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(bus_rdata)); // R11
endmodule

bind lcd_regbank lcd_regbank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_sel    (wr_sel),
  .rd_sel    (rd_sel),
  .rd_stb    (rd_stb),
  .rd_hit    (rd_hit),
  .bus_rdata (bus_rdata),
  .flags     (flags),
  .set_vec   (set_vec),
  .flag_clr  (flag_clr),
  .irq       (irq)
);

// File: tb/tb_lcd_regbank.sv
module tb_lcd_regbank;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, bus_valid, bus_write;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        fr_p, pal_p, syn_p;
  logic        ctl_enable, ctl_mono, ctl_tft;
  logic [1:0]  ctl_irq_en, ctl_pal_mode;
  logic [31:0] ctl_extra, timing2, subpanel;
  logic [10:0] panel_width, panel_height;
  logic [21:0] timing0_aux, timing1_aux;
  logic        st_fr, st_pal, st_syn, irq;

  lcd_regbank dut (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .frame_done_pulse(fr_p), .palette_done_pulse(pal_p), .sync_err_pulse(syn_p),
    .ctl_enable(ctl_enable), .ctl_mono(ctl_mono), .ctl_irq_en(ctl_irq_en),
    .ctl_tft(ctl_tft), .ctl_pal_mode(ctl_pal_mode), .ctl_extra(ctl_extra),
    .panel_width(panel_width), .timing0_aux(timing0_aux),
    .panel_height(panel_height), .timing1_aux(timing1_aux),
    .timing2(timing2), .subpanel(subpanel), .st_frame_done(st_fr),
    .st_palette_done(st_pal), .st_sync_error(st_syn), .irq(irq)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 0; bus_write = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1; bus_write = 0; bus_addr = a;
    @(negedge clk);
    bus_valid = 0;
    d = bus_rdata;
  endtask

  task automatic pulse(logic [2:0] c);
    @(negedge clk);
    fr_p = c[0]; pal_p = c[1]; syn_p = c[2];
    @(negedge clk);
    fr_p = 0; pal_p = 0; syn_p = 0;
  endtask

  function automatic logic [31:0] exp_ctrl(logic [31:0] d);
    logic [31:0] t;
    t = ((d >> 7) & 1);
    return (t << 23) | (((d >> 20) & 3) << 20) | (t << 7) | (((d >> 3) & 3) << 3)
         | (((d >> 1) & 1) << 1) | (d & 1) | (d & 32'h01cff300) | 32'hfe000c34;
  endfunction

  function automatic logic [31:0] pat(int k);
    if (k < 32) return 32'h1 << k;
    case (k)
      32: return 32'hffff_ffff;
      33: return 32'h0000_0000;
      34: return 32'ha5a5_a5a5;
      35: return 32'h5a5a_5a5a;
      36: return 32'h0000_03ff;
      37: return 32'h0030_0099;
      38: return 32'h0080_0080;
      default: return 32'hdead_beef;
    endcase
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r, s_ctrl, s_t0, s_t1, s_t2, s_sp, s_st;
    rst_n = 0; bus_valid = 0; bus_write = 0; bus_addr = 0; bus_wdata = 0;
    fr_p = 0; pal_p = 0; syn_p = 0;
    repeat (3) @(negedge clk);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 rdata", bus_rdata, 0);
    chk("R1 fields", {ctl_enable, ctl_mono, ctl_irq_en, ctl_tft, ctl_pal_mode}, 0);
    chk("R1 flags", {st_fr, st_pal, st_syn}, 0);
    chk("R1 width", panel_width, 1);
    chk("R1 height", panel_height, 1);
    chk("R1 timing2/subpanel", timing2 | subpanel | ctl_extra, 0);
    rst_n = 1;
    rd(8'h00, r); chk("R1 ctrl read", r, 32'hfe000c34);
    rd(8'h04, r); chk("R1 tim0 read", r, 32'h0000000f);
    rd(8'h10, r); chk("R1 status read", r, 0);

    // R2..R5, R7 pattern sweep
    for (int k = 0; k < 40; k++) begin
      logic [31:0] d;
      d = pat(k);
      wr(8'h00, d); rd(8'h00, r); chk("R2 ctrl read", r, exp_ctrl(d));
      chk("R2 ctrl pins", {ctl_enable, ctl_mono, ctl_irq_en, ctl_tft, ctl_pal_mode},
          {d[0], d[1], d[4:3], d[7], d[21:20]});
      chk("R2 extra", ctl_extra, d & 32'h01cff300);
      wr(8'h04, d); rd(8'h04, r); chk("R3 tim0 read", r, d | 32'hf);
      chk("R3 width", panel_width, (d & 32'h3ff) + 1);
      chk("R3 aux", timing0_aux, d >> 10);
      wr(8'h08, d); rd(8'h08, r); chk("R4 tim1 read", r, d);
      chk("R4 height", panel_height, (d & 32'h3ff) + 1);
      chk("R4 aux", timing1_aux, d >> 10);
      wr(8'h0c, d); rd(8'h0c, r); chk("R5 tim2 read", r, d | 32'hfc000000);
      chk("R5 tim2 pin", timing2, d);
      wr(8'h14, d); rd(8'h14, r); chk("R7 subpanel read", r, d & 32'ha1ffffff);
      chk("R7 subpanel pin", subpanel, d & 32'ha1ffffff);
    end

    // R6, R8, R9 enable x event sweep
    for (int en = 0; en < 4; en++) begin
      for (int c = 0; c < 8; c++) begin
        logic [31:0] st;
        logic ex;
        wr(8'h00, 0);
        wr(8'h00, 32'h1 | (en << 3));
        pulse(c[2:0]);
        ex = (c[0] & en[0]) | (c[1] & en[1]) | c[2];
        chk("R9 irq", {31'b0, irq}, {31'b0, ex});
        st = (c[1] << 6) | (c[2] << 2) | c[0];
        rd(8'h10, r); chk("R6 status", r, st);
        wr(8'h10, 32'hffff_ffff); wr(8'h10, 0);
        rd(8'h10, r); chk("R6 status write ignored", r, st);
        wr(8'h00, 32'h1 | (en << 3));
        rd(8'h10, r); chk("R8 flags hold while enabled", r, st);
        wr(8'h00, 32'h0);
        rd(8'h10, r); chk("R8 flags cleared", r, 0);
        chk("R8 irq cleared", {31'b0, irq}, 0);
      end
    end

    // R9 timing: irq rises one cycle after the pulse
    @(negedge clk); syn_p = 1;
    #1 chk("R9 irq before edge", {31'b0, irq}, 0);
    @(negedge clk); syn_p = 0;
    chk("R9 irq after edge", {31'b0, irq}, 1);
    wr(8'h00, 0);
    // R8 pulse wins against the clearing write
    @(negedge clk);
    bus_valid = 1; bus_write = 1; bus_addr = 8'h00; bus_wdata = 0; fr_p = 1;
    @(negedge clk);
    bus_valid = 0; bus_write = 0; fr_p = 0;
    chk("R8 pulse wins over clear", {31'b0, st_fr}, 1);

    // R11 hold of read data
    wr(8'h00, 32'h0000_0002);
    rd(8'h00, r);
    wr(8'h14, 32'h1234_5678);
    repeat (3) @(negedge clk);
    chk("R11 rdata held", bus_rdata, exp_ctrl(32'h2));

    // R10 unmapped sweep
    wr(8'h00, 32'h0030_0099); wr(8'h04, 32'h0000_1234);
    wr(8'h08, 32'h0000_4321); wr(8'h0c, 32'h0000_00aa); wr(8'h14, 32'h0000_5555);
    pulse(3'b001);
    rd(8'h00, s_ctrl); rd(8'h04, s_t0); rd(8'h08, s_t1);
    rd(8'h0c, s_t2); rd(8'h14, s_sp); rd(8'h10, s_st);
    for (int a = 0; a < 256; a++) begin
      if ((a % 4 != 0) || a > 8'h14) wr(a[7:0], 32'hffff_ffff);
    end
    rd(8'h00, r); chk("R10 ctrl untouched", r, s_ctrl);
    rd(8'h04, r); chk("R10 tim0 untouched", r, s_t0);
    rd(8'h08, r); chk("R10 tim1 untouched", r, s_t1);
    rd(8'h0c, r); chk("R10 tim2 untouched", r, s_t2);
    rd(8'h14, r); chk("R10 subpanel untouched", r, s_sp);
    rd(8'h10, r); chk("R10 status untouched", r, s_st);
    for (int a = 0; a < 256; a++) begin
      if ((a % 4 != 0) || a > 8'h14) begin
        rd(8'h00, r);
        rd(a[7:0], r);
        chk("R10 unmapped read zero", r, 0);
      end
    end
    summary();
  end
endmodule